// File: doc/BRIEF.md
# Dual-Lane Adder Around a Fixed Word Adder

This block takes one plain word adder of twice the lane width, which it may not change, and places logic around it. In fused mode the adder produces one full-width sum. In split mode it produces two independent half-width sums, each with its own carry flag, in the same single pass. The low lane adds the low halves of the operands and the high lane adds the high halves.

In split mode the wrapper keeps the low lane's carry out of the high lane without reaching into the fixed adder. It clears the top bit of the low lane in both operands before the adder sees them, so no carry can be produced at that position. The low lane's top sum bit and its carry-out are then rebuilt outside the adder from the adder's output at that bit, which equals the carry into that bit, and the two original operand bits. The high half of the adder output and the adder's own carry-out are used unchanged. The block is purely combinational and has no clock or reset.

Top module: `dual_lane_adder`

## Requirements
- R1: With `mode_i` = 0 (fused), `sum_o` equals (`a_i` + `b_i`) modulo 2^(2*LANE_W), and `hi_carry_o` is the carry out of that full-width addition.
- R2: With `mode_i` = 1 (split), `sum_o[LANE_W-1:0]` equals (`a_i[LANE_W-1:0]` + `b_i[LANE_W-1:0]`) modulo 2^LANE_W, for every operand value including the corner values 0, 2^(LANE_W-1)-1, 2^(LANE_W-1) and 2^LANE_W-1.
- R3: With `mode_i` = 1, `sum_o[2*LANE_W-1:LANE_W]` equals (`a_i[2*LANE_W-1:LANE_W]` + `b_i[2*LANE_W-1:LANE_W]`) modulo 2^LANE_W, whatever the low-lane operands are. No carry passes from the low lane into the high lane.
- R4: With `mode_i` = 1, `lo_carry_o` is the carry out of the low-lane addition.
- R5: With `mode_i` = 1, `hi_carry_o` is the carry out of the high-lane addition.
- R6: With `mode_i` = 0, `lo_carry_o` is the carry out of bit LANE_W-1 of the full-width addition, which is the carry into bit LANE_W.
- R7: The mode encoding is 0 for fused and 1 for split. Outputs follow a change of `mode_i` or of either operand with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0 = one full-width sum, 1 = two independent lane sums |
| a_i | input | 2*LANE_W | First operand; bits LANE_W-1..0 form the low lane |
| b_i | input | 2*LANE_W | Second operand, with the same lane layout |
| sum_o | output | 2*LANE_W | Full-width sum, or the two lane sums side by side |
| lo_carry_o | output | 1 | Low-lane carry in split mode; carry out of bit LANE_W-1 in fused mode |
| hi_carry_o | output | 1 | High-lane carry in split mode; full-width carry in fused mode |

## Verification
The assertions are immediate and evaluated on combinational settling. They assume `mode_i` and both operands are known two-state values and that the fixed adder inside is a correct binary adder. Under those conditions the rebuilt top bit, and the carry into the high lane read back from the adder output, must agree with arithmetic on the original operands. The stimulus drives only defined values. On a four-bit-lane copy it steps through every operand pair in both modes. On the default width it combines the four lane corner values in every lane of both operands and adds random words.

// File: rtl/dla_pkg.sv
package dla_pkg;

  typedef enum logic {
    MODE_FUSED = 1'b0,
    MODE_SPLIT = 1'b1
  } dla_mode_e;

  // Sum bit of a one-bit full adder.
  function automatic logic xor3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // Carry of a one-bit full adder.
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | ((x ^ y) & z);
  endfunction

  // Carry that entered a bit position, recovered from both operand bits and the sum bit there.
  function automatic logic carry_into(input logic opa, input logic opb, input logic sumbit);
    return opa ^ opb ^ sumbit;
  endfunction

endpackage

// File: rtl/fixed_adder.sv
module fixed_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  output logic [W-1:0] add_s,
  output logic         add_co
);
  // Plain binary adder, treated as untouchable by the wrapper.
  assign {add_co, add_s} = {1'b0, add_a} + {1'b0, add_b};
endmodule

// File: rtl/dla_operand_gate.sv
module dla_operand_gate
  import dla_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  dla_mode_e              mode,
  input  logic [2*LANE_W-1:0]    opa,
  input  logic [2*LANE_W-1:0]    opb,
  output logic [2*LANE_W-1:0]    gated_a,
  output logic [2*LANE_W-1:0]    gated_b
);
  localparam int WORD_W = 2 * LANE_W;
  localparam int CUT    = LANE_W - 1;
  localparam logic [WORD_W-1:0] CUT_MASK = ~({{(WORD_W-1){1'b0}}, 1'b1} << CUT);

  logic [WORD_W-1:0] mask;

  always_comb begin
    mask    = (mode == MODE_SPLIT) ? CUT_MASK : '1;
    gated_a = opa & mask;
    gated_b = opb & mask;
  end
endmodule

// File: rtl/dla_lane_repair.sv
module dla_lane_repair
  import dla_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  dla_mode_e            mode,
  input  logic                 a_cut_bit,
  input  logic                 b_cut_bit,
  input  logic                 a_hi_lsb,
  input  logic                 b_hi_lsb,
  input  logic [2*LANE_W-1:0]  raw_sum,
  input  logic                 raw_co,
  output logic [2*LANE_W-1:0]  fixed_sum,
  output logic                 lo_carry,
  output logic                 hi_carry,
  output logic                 bridge_carry
);
  localparam int CUT = LANE_W - 1;

  logic cut_carry_in;

  always_comb begin
    // The carry into the high lane, read back from the adder's output at bit LANE_W.
    bridge_carry = carry_into(a_hi_lsb, b_hi_lsb, raw_sum[LANE_W]);
    // With the cut bit cleared in both operands, the adder output there is the carry into it.
    cut_carry_in = raw_sum[CUT];
    fixed_sum    = raw_sum;
    hi_carry     = raw_co;
    if (mode == MODE_SPLIT) begin
      fixed_sum[CUT] = xor3(cut_carry_in, a_cut_bit, b_cut_bit);
      lo_carry       = maj3(a_cut_bit, b_cut_bit, cut_carry_in);
    end else begin
      lo_carry       = bridge_carry;
    end
  end

  always_comb begin
    if (mode == MODE_SPLIT)
      AST_NO_CROSS_CARRY: assert (bridge_carry == 1'b0) else $error("carry leaked into high lane"); // R3
  end
endmodule

// File: rtl/dual_lane_adder.sv
module dual_lane_adder
  import dla_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                 mode_i,
  input  logic [2*LANE_W-1:0]  a_i,
  input  logic [2*LANE_W-1:0]  b_i,
  output logic [2*LANE_W-1:0]  sum_o,
  output logic                 lo_carry_o,
  output logic                 hi_carry_o
);
  localparam int WORD_W = 2 * LANE_W;
  localparam int CUT    = LANE_W - 1;

  dla_mode_e         mode;
  logic [WORD_W-1:0] gated_a;
  logic [WORD_W-1:0] gated_b;
  logic [WORD_W-1:0] raw_sum;
  logic              raw_co;
  logic              bridge_carry;

  assign mode = dla_mode_e'(mode_i);

  dla_operand_gate #(.LANE_W(LANE_W)) u_gate (
    .mode    (mode),
    .opa     (a_i),
    .opb     (b_i),
    .gated_a (gated_a),
    .gated_b (gated_b)
  );

  fixed_adder #(.W(WORD_W)) u_core (
    .add_a  (gated_a),
    .add_b  (gated_b),
    .add_s  (raw_sum),
    .add_co (raw_co)
  );

  dla_lane_repair #(.LANE_W(LANE_W)) u_repair (
    .mode         (mode),
    .a_cut_bit    (a_i[CUT]),
    .b_cut_bit    (b_i[CUT]),
    .a_hi_lsb     (a_i[LANE_W]),
    .b_hi_lsb     (b_i[LANE_W]),
    .raw_sum      (raw_sum),
    .raw_co       (raw_co),
    .fixed_sum    (sum_o),
    .lo_carry     (lo_carry_o),
    .hi_carry     (hi_carry_o),
    .bridge_carry (bridge_carry)
  );

  // Lane arithmetic recomputed directly from the ports.
  logic [LANE_W:0]   chk_lo;
  logic [LANE_W:0]   chk_hi;
  logic [WORD_W:0]   chk_word;

  always_comb begin
    chk_lo   = {1'b0, a_i[LANE_W-1:0]} + {1'b0, b_i[LANE_W-1:0]};
    chk_hi   = {1'b0, a_i[WORD_W-1:LANE_W]} + {1'b0, b_i[WORD_W-1:LANE_W]};
    chk_word = {1'b0, a_i} + {1'b0, b_i};
    if (mode_i == 1'b0) begin
      AST_FUSED_WORD: assert ({hi_carry_o, sum_o} == chk_word) else $error("fused sum wrong"); // R1
      AST_FUSED_MID_CARRY: assert (lo_carry_o == chk_lo[LANE_W]) else $error("mid carry wrong"); // R6
    end else begin
      AST_LO_LANE_SUM: assert (sum_o[LANE_W-1:0] == chk_lo[LANE_W-1:0]) else $error("low lane wrong"); // R2
      AST_HI_LANE_SUM: assert (sum_o[WORD_W-1:LANE_W] == chk_hi[LANE_W-1:0]) else $error("high lane wrong"); // R3
      AST_LO_LANE_CARRY: assert (lo_carry_o == chk_lo[LANE_W]) else $error("low carry wrong"); // R4
      AST_HI_LANE_CARRY: assert (hi_carry_o == chk_hi[LANE_W]) else $error("high carry wrong"); // R5
    end
  end
endmodule

// File: tb/dual_lane_adder_bench.sv
module dual_lane_adder_bench;
  localparam int BIG_W   = 16;
  localparam int SMALL_W = 4;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  logic                 mode_big;
  logic [2*BIG_W-1:0]   a_big, b_big, sum_big;
  logic                 lo_big, hi_big;

  logic                 mode_sm;
  logic [2*SMALL_W-1:0] a_sm, b_sm, sum_sm;
  logic                 lo_sm, hi_sm;

  dual_lane_adder #(.LANE_W(BIG_W)) u_dual_lane_adder (
    .mode_i(mode_big), .a_i(a_big), .b_i(b_big),
    .sum_o(sum_big), .lo_carry_o(lo_big), .hi_carry_o(hi_big)
  );

  dual_lane_adder #(.LANE_W(SMALL_W)) u_small (
    .mode_i(mode_sm), .a_i(a_sm), .b_i(b_sm),
    .sum_o(sum_sm), .lo_carry_o(lo_sm), .hi_carry_o(hi_sm)
  );

  task automatic check(input string req, input string what, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // Independent reference: lane width lw, returns expected sum and both flags.
  task automatic expect_vals(input int lw, input bit split, input longint a, input longint b,
                             output longint esum, output longint elo, output longint ehi);
    longint lmask, wmask, ls, hs, full;
    lmask = (longint'(1) << lw) - 1;
    wmask = (longint'(1) << (2*lw)) - 1;
    ls    = (a & lmask) + (b & lmask);
    hs    = ((a >> lw) & lmask) + ((b >> lw) & lmask);
    if (!split) begin
      full = (a & wmask) + (b & wmask);
      esum = full & wmask;
      ehi  = (full >> (2*lw)) & 1;
      elo  = (ls >> lw) & 1;
    end else begin
      esum = ((hs & lmask) << lw) | (ls & lmask);
      elo  = (ls >> lw) & 1;
      ehi  = (hs >> lw) & 1;
    end
  endtask

  task automatic compare(input int lw, input bit split, input longint a, input longint b,
                         input longint gs, input longint glo, input longint ghi);
    longint es, elo, ehi, lmask;
    lmask = (longint'(1) << lw) - 1;
    expect_vals(lw, split, a, b, es, elo, ehi);
    if (!split) begin // R7: encoding 0 is fused
      check("R1", "fused sum", gs, es);
      check("R1", "fused carry", ghi, ehi);
      check("R6", "mid carry", glo, elo);
    end else begin   // R7: encoding 1 is split
      check("R2", "low lane sum", gs & lmask, es & lmask);
      check("R3", "high lane sum", gs >> lw, es >> lw);
      check("R4", "low lane carry", glo, elo);
      check("R5", "high lane carry", ghi, ehi);
    end
  endtask

  task automatic run_big(input bit split, input logic [31:0] a, input logic [31:0] b);
    mode_big = split; a_big = a; b_big = b;
    #1;
    compare(BIG_W, split, longint'(a), longint'(b), longint'(sum_big), longint'(lo_big), longint'(hi_big));
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WATCHDOG_CYCLES) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [4];
    corners[0] = 16'h0000; corners[1] = 16'h7FFF; corners[2] = 16'h8000; corners[3] = 16'hFFFF;

    // Quiet state with zero operands: all outputs zero (R1, R2).
    mode_big = 1'b0; a_big = '0; b_big = '0;
    mode_sm  = 1'b0; a_sm  = '0; b_sm  = '0;
    #2;
    check("R1", "idle sum", longint'(sum_big), 0);
    check("R1", "idle carry", longint'(hi_big), 0);
    check("R2", "idle small sum", longint'(sum_sm), 0);

    // Carry leaving the low lane must stop at the boundary in split mode (R3, R4).
    run_big(1'b1, 32'h0000_FFFF, 32'h0000_0001);
    run_big(1'b1, 32'h0000_8000, 32'h0000_8000);
    run_big(1'b0, 32'h0000_FFFF, 32'h0000_0001);
    run_big(1'b1, 32'hFFFF_FFFF, 32'h0001_0001);
    run_big(1'b0, 32'hFFFF_FFFF, 32'h0000_0001);

    // Exhaustive sweep of the four-bit-lane copy in both modes.
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          mode_sm = m[0]; a_sm = a[7:0]; b_sm = b[7:0];
          #1;
          compare(SMALL_W, m[0], longint'(a), longint'(b),
                  longint'(sum_sm), longint'(lo_sm), longint'(hi_sm));
          #1;
        end
      end
    end

    // Corner values in every lane of both operands at full width.
    for (int m = 0; m < 2; m++)
      for (int al = 0; al < 4; al++)
        for (int ah = 0; ah < 4; ah++)
          for (int bl = 0; bl < 4; bl++)
            for (int bh = 0; bh < 4; bh++)
              run_big(m[0], {corners[ah], corners[al]}, {corners[bh], corners[bl]});

    // Random words in both modes.
    for (int i = 0; i < 3000; i++)
      run_big(i[0], $urandom(), $urandom());

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule